// File: doc/BRIEF.md
# Split-Upper Scratchpad Memory with Stack Pointer

This block holds the 256-byte internal scratchpad of an 8-bit microcontroller core and steers each access to the right place. The core presents an 8-bit address, an access mode and read/write strobes. The lower 128 addresses always reach RAM. The upper 128 addresses reach either RAM or an external special-function-register bus, depending on the mode: a direct access goes to the register bus, and an indirect access goes to the upper RAM bytes.

The block also keeps the stack pointer. A push or pop always addresses RAM indirectly, so the stack can use all 256 bytes. The core can read and write the stack pointer as a register at direct address 0x81, which is served locally and never reaches the register bus. Every read completes one cycle after it is accepted, whatever its source, and is marked by a one-cycle valid pulse. The lowest 48 bytes also serve the register and bit addressing modes. Those modes are plain direct accesses at this interface, because the bit handling lives in the core.

Top module: `iram_steer`

## Requirements
- R1: With mode 00 (direct) or 01 (indirect), addresses 0x00 to 0x7F reach the same RAM byte, so a byte written in one mode reads back in the other.
- R2: A direct access to an upper address other than 0x81 raises sfr_sel for that cycle only, with sfr_addr equal to addr, sfr_we equal to wr_en and sfr_wdata equal to wdata. The RAM byte at that address is left unchanged.
- R3: For a direct read of an upper address other than 0x81, the value on sfr_rdata in the select cycle appears on rdata in the next cycle, together with rd_valid.
- R4: An indirect access to an address from 0x80 to 0xFF reads or writes the upper RAM byte, and sfr_sel stays low.
- R5: The stack pointer resets to 0x07. A direct read or write of address 0x81 reads or loads it without raising sfr_sel.
- R6: Mode 10 with wr_en (push) first adds 1 to the stack pointer and then writes wdata at the new pointer. Mode 11 with rd_en (pop) returns the byte at the pointer and then subtracts 1. Both wrap modulo 256, and addr is ignored in both modes.
- R7: Push and pop address RAM indirectly, so a stack byte at 0x80 or above goes to RAM and can be read back with an indirect access.
- R8: Every accepted read puts its data on rdata one cycle later, and rd_valid is high for exactly that cycle. Without a read, rdata keeps its last value and rd_valid stays low.
- R9: In modes 00 and 01, wr_en takes priority and a simultaneous rd_en is ignored. In mode 10 rd_en is ignored, and in mode 11 wr_en is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Access mode: 00 direct, 01 indirect, 10 push, 11 pop |
| addr | input | 8 | Access address (ignored in push and pop) |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid one cycle after the read |
| rd_valid | output | 1 | Read data valid pulse |
| sp_out | output | 8 | Current stack pointer |
| sfr_sel | output | 1 | Register bus select, one cycle |
| sfr_we | output | 1 | Register bus write |
| sfr_addr | output | 8 | Register bus address |
| sfr_wdata | output | 8 | Register bus write data |
| sfr_rdata | input | 8 | Register bus read data, sampled in the select cycle |

## Verification
Directed cases cover the following:
- A byte is written directly and read back indirectly in the lower half. This separates shared storage from two separate arrays.
- An upper address is written indirectly and then accessed directly. This shows whether the direct access goes to the register bus or leaks into RAM.
- Pushes start from 0x7F and from 0xFF. These show whether the stack crosses into the upper RAM bytes and wraps to address zero.
- Both strobes are raised together in every mode. This exposes the priority rules.

Constrained random operations then mix all four modes over all addresses, including 0x81 and varying register-bus data. A bench model checks every output after each operation.

// File: rtl/iram_pkg.sv
package iram_pkg;
  typedef enum logic [1:0] {
    M_DIRECT   = 2'b00,
    M_INDIRECT = 2'b01,
    M_PUSH     = 2'b10,
    M_POP      = 2'b11
  } acc_mode_e;

  // Top half of the address space: the half that splits by mode.
  function automatic logic f_upper(input logic [7:0] a);
    return a[7];
  endfunction

  // One stack step, wrapping modulo 256.
  function automatic logic [7:0] f_sp_step(input logic [7:0] sp, input logic up);
    return up ? sp + 8'd1 : sp - 8'd1;
  endfunction
endpackage

// File: rtl/iram_decode.sv
module iram_decode
  import iram_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] SP_ADDR = 8'h81
) (
  input  logic [1:0]    mode,
  input  logic [AW-1:0] addr,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] sp,
  output logic          ram_we,
  output logic          ram_re,
  output logic [AW-1:0] ram_addr,
  output logic          sfr_acc,
  output logic          sfr_wr,
  output logic          sp_wr,
  output logic          sp_rd,
  output logic          push_ev,
  output logic          pop_ev
);
  logic rd_plain;
  assign rd_plain = rd_en & ~wr_en;

  always_comb begin
    ram_we   = 1'b0;
    ram_re   = 1'b0;
    ram_addr = addr;
    sfr_acc  = 1'b0;
    sfr_wr   = 1'b0;
    sp_wr    = 1'b0;
    sp_rd    = 1'b0;
    push_ev  = 1'b0;
    pop_ev   = 1'b0;
    unique case (acc_mode_e'(mode))
      M_DIRECT: begin
        if (!f_upper(addr)) begin
          ram_we = wr_en;
          ram_re = rd_plain;
        end else if (addr == SP_ADDR) begin
          sp_wr = wr_en;
          sp_rd = rd_plain;
        end else begin
          sfr_acc = wr_en | rd_en;
          sfr_wr  = wr_en;
        end
      end
      M_INDIRECT: begin
        ram_we = wr_en;
        ram_re = rd_plain;
      end
      M_PUSH: begin
        ram_addr = f_sp_step(sp, 1'b1);
        ram_we   = wr_en;
        push_ev  = wr_en;
      end
      M_POP: begin
        ram_addr = sp;
        ram_re   = rd_en;
        pop_ev   = rd_en;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/iram_array.sv
module iram_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] a,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[a] <= d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (re) q <= mem[a];
  end
endmodule

// File: rtl/iram_stack_ptr.sv
module iram_stack_ptr
  import iram_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] SP_RESET = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  input  logic          dec,
  output logic [AW-1:0] sp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sp <= SP_RESET;
    else if (load) sp <= load_val;
    else if (inc)  sp <= f_sp_step(sp, 1'b1);
    else if (dec)  sp <= f_sp_step(sp, 1'b0);
  end
endmodule

// File: rtl/iram_steer.sv
module iram_steer #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] SP_ADDR  = 8'h81,
  parameter logic [AW-1:0] SP_RESET = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] addr,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rd_valid,
  output logic [AW-1:0] sp_out,
  output logic          sfr_sel,
  output logic          sfr_we,
  output logic [AW-1:0] sfr_addr,
  output logic [DW-1:0] sfr_wdata,
  input  logic [DW-1:0] sfr_rdata
);
  logic          ram_we, ram_re, sfr_acc, sfr_wr, sp_wr, sp_rd, push_ev, pop_ev;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_q;
  logic          read_acc;
  logic          src_ram_q, valid_q;
  logic [DW-1:0] cap_q;

  iram_decode #(.AW(AW), .SP_ADDR(SP_ADDR)) u_dec (
    .mode(mode), .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .sp(sp_out),
    .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr),
    .sfr_acc(sfr_acc), .sfr_wr(sfr_wr), .sp_wr(sp_wr), .sp_rd(sp_rd),
    .push_ev(push_ev), .pop_ev(pop_ev)
  );

  iram_array #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .re(ram_re),
    .a(ram_addr), .d(wdata), .q(ram_q)
  );

  iram_stack_ptr #(.AW(AW), .SP_RESET(SP_RESET)) u_sp (
    .clk(clk), .rst_n(rst_n), .load(sp_wr), .load_val(wdata[AW-1:0]),
    .inc(push_ev), .dec(pop_ev), .sp(sp_out)
  );

  assign sfr_sel   = sfr_acc;
  assign sfr_we    = sfr_wr;
  assign sfr_addr  = addr;
  assign sfr_wdata = wdata;

  // An accepted read from any source.
  assign read_acc = ram_re | sp_rd | (sfr_acc & ~sfr_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      src_ram_q <= 1'b0;
      cap_q     <= '0;
    end else begin
      valid_q <= read_acc;
      if (read_acc) begin
        src_ram_q <= ram_re;
        if (!ram_re) cap_q <= sp_rd ? DW'(sp_out) : sfr_rdata;
      end
    end
  end

  assign rd_valid = valid_q;
  assign rdata    = src_ram_q ? ram_q : cap_q;
endmodule

// File: rtl/iram_steer_chk.sv
module iram_steer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic [7:0] addr,
  input logic       rd_en,
  input logic       wr_en,
  input logic       sfr_sel,
  input logic       rd_valid,
  input logic [7:0] sp_out,
  input logic       ram_we,
  input logic       push_ev,
  input logic       pop_ev
);
  logic rd_taken;
  assign rd_taken = (mode == 2'b11) ? rd_en : ((mode != 2'b10) && rd_en && !wr_en);

  assert_sfr_only_direct_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_sel |-> (mode == 2'b00 && addr[7]));
  assert_no_ram_write_on_sfr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && addr[7] && wr_en) |-> !ram_we);
  assert_indirect_no_sfr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> !sfr_sel);
  assert_push_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push_ev |=> sp_out == $past(sp_out) + 8'd1);
  assert_pop_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ev |=> sp_out == $past(sp_out) - 8'd1);
  assert_read_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_taken |=> rd_valid);
  assert_no_read_no_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_taken |=> !rd_valid);
endmodule

bind iram_steer iram_steer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .rd_en(rd_en),
  .wr_en(wr_en), .sfr_sel(sfr_sel), .rd_valid(rd_valid), .sp_out(sp_out),
  .ram_we(ram_we), .push_ev(push_ev), .pop_ev(pop_ev)
);

// File: tb/sim_iram_steer.sv
module sim_iram_steer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] addr = 8'h00;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = 8'h00, sfr_rdata = 8'h00;
  logic [7:0] rdata, sp_out, sfr_addr, sfr_wdata;
  logic       rd_valid, sfr_sel, sfr_we;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [7:0] m_ram [256];
  logic [7:0] m_sp, m_last;

  always #5 clk = ~clk;

  iram_steer u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .sp_out(sp_out), .sfr_sel(sfr_sel), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  task automatic chk(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // Bench restatement of the routing: 0 ram, 1 sfr bus, 2 stack pointer reg, 3 push, 4 pop.
  function automatic int route(input logic [1:0] m, input logic [7:0] a);
    if (m == 2'b10) return 3;
    if (m == 2'b11) return 4;
    if (m == 2'b01 || a < 8'h80) return 0;
    if (a == 8'h81) return 2;
    return 1;
  endfunction

  task automatic op(input logic [1:0] m, input logic [7:0] a, input bit w, input bit r,
                    input logic [7:0] d, input string tag);
    int rt;
    bit rd_ok, wr_ok, e_sel;
    logic [7:0] e_data, bus_d;
    rt = route(m, a);
    bus_d = 8'($urandom);
    @(negedge clk);
    mode = m; addr = a; wr_en = w; rd_en = r; wdata = d; sfr_rdata = bus_d;
    wr_ok = (rt == 4) ? 1'b0 : w;
    rd_ok = (rt == 4) ? r : (rt == 3) ? 1'b0 : (r && !w);
    e_sel = (rt == 1) && (w || r);
    #1;
    chk(tag, "sfr_sel", {7'd0, sfr_sel}, {7'd0, e_sel});
    if (e_sel) begin
      chk(tag, "sfr_we", {7'd0, sfr_we}, {7'd0, w});
      chk(tag, "sfr_addr", sfr_addr, a);
      chk(tag, "sfr_wdata", sfr_wdata, d);
    end
    e_data = m_last;
    case (rt)
      0: begin
        if (rd_ok) e_data = m_ram[a];
        if (wr_ok) m_ram[a] = d;
      end
      1: if (rd_ok) e_data = bus_d;
      2: begin
        if (rd_ok) e_data = m_sp;
        if (wr_ok) m_sp = d;
      end
      3: if (wr_ok) begin m_sp = m_sp + 8'd1; m_ram[m_sp] = d; end
      4: if (rd_ok) begin e_data = m_ram[m_sp]; m_sp = m_sp - 8'd1; end
      default: ;
    endcase
    @(posedge clk);
    #1;
    chk(tag, "rd_valid", {7'd0, rd_valid}, {7'd0, rd_ok});
    chk(tag, "rdata", rdata, e_data);
    chk(tag, "sp", sp_out, m_sp);
    m_last = e_data;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    string tg;
    void'($urandom(32'h1d2c));
    m_sp = 8'h07; m_last = 8'h00;
    for (int i = 0; i < 256; i++) m_ram[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    chk("R5", "reset sp", sp_out, 8'h07);
    chk("R8", "reset rd_valid", {7'd0, rd_valid}, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // Clear RAM through indirect writes so the model is defined.
    for (int i = 0; i < 256; i++) op(2'b01, 8'(i), 1, 0, 8'h00, "R4");
    // R1: direct write, indirect read of the same lower byte, and the reverse.
    op(2'b00, 8'h10, 1, 0, 8'hA5, "R1");
    op(2'b01, 8'h10, 0, 1, 8'h00, "R1");
    op(2'b01, 8'h2F, 1, 0, 8'h3C, "R1");
    op(2'b00, 8'h2F, 0, 1, 8'h00, "R1");
    // R4 and R2: indirect upper byte, direct access to the same address goes to the bus.
    op(2'b01, 8'h90, 1, 0, 8'h77, "R4");
    op(2'b00, 8'h90, 1, 0, 8'hEE, "R2");
    op(2'b01, 8'h90, 0, 1, 8'h00, "R4");
    op(2'b00, 8'h90, 0, 1, 8'h00, "R3");
    // R8: idle keeps rdata.
    op(2'b00, 8'h00, 0, 0, 8'h00, "R8");
    // R5: stack pointer register at 0x81.
    op(2'b00, 8'h81, 0, 1, 8'h00, "R5");
    op(2'b00, 8'h81, 1, 0, 8'h7F, "R5");
    // R7: push crosses into the upper RAM bytes.
    op(2'b10, 8'h33, 1, 0, 8'hC1, "R7");
    op(2'b01, 8'h80, 0, 1, 8'h00, "R7");
    op(2'b11, 8'h00, 0, 1, 8'h00, "R7");
    // R6: wrap at 0xFF and back.
    op(2'b00, 8'h81, 1, 0, 8'hFF, "R6");
    op(2'b10, 8'h55, 1, 0, 8'h42, "R6");
    op(2'b01, 8'h00, 0, 1, 8'h00, "R6");
    op(2'b11, 8'hAA, 0, 1, 8'h00, "R6");
    // R9: both strobes together in every mode.
    op(2'b00, 8'h20, 1, 1, 8'h5A, "R9");
    op(2'b01, 8'hC0, 1, 1, 8'h6B, "R9");
    op(2'b00, 8'hA0, 1, 1, 8'h7C, "R9");
    op(2'b10, 8'h00, 1, 1, 8'h8D, "R9");
    op(2'b11, 8'h00, 1, 1, 8'h9E, "R9");
    op(2'b01, 8'h20, 0, 1, 8'h00, "R9");

    // Constrained random mix.
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] m;
      logic [7:0] a;
      m = 2'($urandom);
      a = ($urandom_range(0, 7) == 0) ? 8'h81 : 8'($urandom);
      case (route(m, a))
        0: tg = (a[7]) ? "R4" : "R1";
        1: tg = "R2";
        2: tg = "R5";
        default: tg = "R6";
      endcase
      op(m, a, 1'($urandom), 1'($urandom), 8'($urandom), tg);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule